// File: doc/BRIEF.md
# Stack Doubleword Logical Shifter

This block is the logical shift unit of a register-stack machine. It shifts a 32-bit doubleword taken from the top of the stack left or right, filling vacated bits with zeros. The amount comes from one of two places. A nonzero count field in the instruction gives the amount directly and shifts the top two words. A zero count field makes the unit read a signed dynamic count from the top word. In that case it shifts the doubleword held in the second and third words and reports that one word is popped.

The result goes back to the top two stack positions, with the high half one position below the top. A two-bit condition code describes the result as a signed 32-bit value. A dynamic count outside the legal window yields zero and raises a debug flag, so the outcome is always deterministic. The unit can be built as a single-cycle barrel shifter or with an output register stage.

Top module: `shdw_stack_shifter`

## Requirements
- R1: With a nonzero count field, the doubleword {stk_b (high), stk_a (low)} is shifted by the field value and pop_one is 0.
- R2: With a zero count field, the doubleword {stk_c (high), stk_b (low)} is shifted by stk_a, read as a signed two's-complement count, and pop_one is 1.
- R3: dir_right = 0 selects a left shift and dir_right = 1 selects a right shift. Both are logical, so vacated bit positions are zero.
- R4: A count from 32 up to 255, whether static or dynamic, gives an all-zero result with range_err low.
- R5: A dynamic count below 0 or above 255 gives an all-zero result with range_err high. range_err is low for every other operation.
- R6: cc encodes the signed 32-bit result: 2'b01 when negative, 2'b10 when zero, 2'b00 when positive.
- R7: With REGISTERED = 1, res_valid and the results appear one clock after op_valid. With REGISTERED = 0, they follow the inputs in the same cycle.
- R8: While rst_n is low, the registered variant holds res_valid and range_err at 0.
- R9: res_hi carries result bits 31:16 and res_lo carries bits 15:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A shift operation is presented this cycle |
| dir_right | input | 1 | 0 = shift left, 1 = shift right |
| cnt_field | input | FLD_W | Static count from the instruction; zero selects the dynamic count |
| stk_a | input | WORD_W | Top-of-stack word |
| stk_b | input | WORD_W | Second stack word |
| stk_c | input | WORD_W | Third stack word |
| res_valid | output | 1 | Result outputs are valid |
| res_hi | output | WORD_W | High word of the result (second stack position) |
| res_lo | output | WORD_W | Low word of the result (top of stack) |
| pop_one | output | 1 | One stack word is consumed by the operation |
| cc | output | 2 | Condition code of the result |
| range_err | output | 1 | Dynamic count was outside the legal window |

## Verification
The bench builds two copies of the block with 16-bit words, a 6-bit count field and a dynamic limit of 255. One copy is registered and the other is combinational, so both generate variants run against the same reference model on the same stimulus. At this width the doubleword is 32 bits wide. Static counts 32 to 63 and dynamic counts 32 to 255 therefore land in the all-zero band. The signed count word also reaches both edges of the legal window (-1, 0, 255, 256) as well as its extreme values.

// File: rtl/shdw_pkg.sv
package shdw_pkg;

   typedef enum logic [1:0] {
      CC_POS  = 2'b00,
      CC_NEG  = 2'b01,
      CC_ZERO = 2'b10
   } cc_e;

endpackage

// File: rtl/shdw_opsel.sv
module shdw_opsel #(
   parameter int WORD_W  = 16,
   parameter int FLD_W   = 6,
   parameter int DYN_MAX = 255,
   parameter int DW      = 2 * WORD_W,
   parameter int SH_W    = $clog2(DW),
   parameter int CNT_AW  = $clog2(DYN_MAX + 1)
)(
   input  logic [FLD_W-1:0]  fld,
   input  logic [WORD_W-1:0] wa,
   input  logic [WORD_W-1:0] wb,
   input  logic [WORD_W-1:0] wc,
   output logic [DW-1:0]     src,
   output logic [SH_W-1:0]   shamt,
   output logic              kill,
   output logic              dyn,
   output logic              bad
);

   logic [CNT_AW-1:0] amt;
   logic              negative;
   logic              above;
   logic              wide;

   assign dyn      = (fld == '0);
   assign src      = dyn ? {wc, wb} : {wb, wa};
   assign negative = wa[WORD_W-1];
   assign above    = (wa > WORD_W'(DYN_MAX));
   assign bad      = dyn && (negative || above);
   assign amt      = dyn ? wa[CNT_AW-1:0] : CNT_AW'(fld);
   assign wide     = (amt > CNT_AW'(DW - 1));
   assign kill     = bad || wide;
   assign shamt    = amt[SH_W-1:0];

endmodule

// File: rtl/shdw_barrel.sv
module shdw_barrel #(
   parameter int DW   = 32,
   parameter int SH_W = $clog2(DW)
)(
   input  logic [DW-1:0]   din,
   input  logic [SH_W-1:0] amt,
   input  logic            right,
   input  logic            kill,
   output logic [DW-1:0]   dout
);

   logic [DW-1:0] fwd;
   logic [DW-1:0] bwd;
   logic [DW-1:0] stg [0:SH_W];

   // A right shift is a left shift of the bit-reversed word.
   for (genvar i = 0; i < DW; i++) begin : g_rev_in
      assign fwd[i] = right ? din[DW-1-i] : din[i];
   end

   assign stg[0] = fwd;

   for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int SH = 1 << s;
      assign stg[s+1] = amt[s] ? {stg[s][DW-1-SH:0], {SH{1'b0}}} : stg[s];
   end

   for (genvar i = 0; i < DW; i++) begin : g_rev_out
      assign bwd[i] = right ? stg[SH_W][DW-1-i] : stg[SH_W][i];
   end

   assign dout = kill ? '0 : bwd;

endmodule

// File: rtl/shdw_ccgen.sv
module shdw_ccgen import shdw_pkg::*; #(
   parameter int DW = 32
)(
   input  logic [DW-1:0] val,
   output logic [1:0]    cc
);

   cc_e code;

   always_comb begin
      if (val[DW-1])
         code = CC_NEG;
      else if (val == '0)
         code = CC_ZERO;
      else
         code = CC_POS;
   end

   assign cc = code;

endmodule

// File: rtl/shdw_stack_shifter.sv
module shdw_stack_shifter import shdw_pkg::*; #(
   parameter int WORD_W     = 16,
   parameter int FLD_W      = 6,
   parameter int DYN_MAX    = 255,
   parameter bit REGISTERED = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic              dir_right,
   input  logic [FLD_W-1:0]  cnt_field,
   input  logic [WORD_W-1:0] stk_a,
   input  logic [WORD_W-1:0] stk_b,
   input  logic [WORD_W-1:0] stk_c,
   output logic              res_valid,
   output logic [WORD_W-1:0] res_hi,
   output logic [WORD_W-1:0] res_lo,
   output logic              pop_one,
   output logic [1:0]        cc,
   output logic              range_err
);

   localparam int DW     = 2 * WORD_W;
   localparam int SH_W   = $clog2(DW);
   localparam int CNT_AW = $clog2(DYN_MAX + 1);

   if ((1 << SH_W) != DW) begin : g_chk_pow2
      $error("doubleword width must be a power of two");
   end
   if (DYN_MAX < DW - 1) begin : g_chk_dynmin
      $error("dynamic limit must cover every in-range shift amount");
   end
   if (DYN_MAX >= (1 << (WORD_W - 1))) begin : g_chk_dynmax
      $error("dynamic limit must be positive in a signed word");
   end
   if (((1 << FLD_W) - 1) > DYN_MAX) begin : g_chk_fld
      $error("count field must not exceed the dynamic limit");
   end

   logic [DW-1:0]   src;
   logic [SH_W-1:0] shamt;
   logic            kill;
   logic            dyn;
   logic            bad;
   logic [DW-1:0]   shifted;
   logic [1:0]      cc_nxt;

   shdw_opsel #(
      .WORD_W (WORD_W),
      .FLD_W  (FLD_W),
      .DYN_MAX(DYN_MAX),
      .DW     (DW),
      .SH_W   (SH_W),
      .CNT_AW (CNT_AW)
   ) u_opsel (
      .fld  (cnt_field),
      .wa   (stk_a),
      .wb   (stk_b),
      .wc   (stk_c),
      .src  (src),
      .shamt(shamt),
      .kill (kill),
      .dyn  (dyn),
      .bad  (bad)
   );

   shdw_barrel #(
      .DW  (DW),
      .SH_W(SH_W)
   ) u_barrel (
      .din  (src),
      .amt  (shamt),
      .right(dir_right),
      .kill (kill),
      .dout (shifted)
   );

   shdw_ccgen #(
      .DW(DW)
   ) u_ccgen (
      .val(shifted),
      .cc (cc_nxt)
   );

   if (REGISTERED) begin : g_reg
      logic            vld_q;
      logic [DW-1:0]   res_q;
      logic            pop_q;
      logic [1:0]      cc_q;
      logic            err_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            res_q <= '0;
            pop_q <= 1'b0;
            cc_q  <= CC_POS;
            err_q <= 1'b0;
         end else begin
            vld_q <= op_valid;
            if (op_valid) begin
               res_q <= shifted;
               pop_q <= dyn;
               cc_q  <= cc_nxt;
               err_q <= bad;
            end
         end
      end

      assign res_valid = vld_q;
      assign res_hi    = res_q[DW-1:WORD_W];
      assign res_lo    = res_q[WORD_W-1:0];
      assign pop_one   = pop_q;
      assign cc        = cc_q;
      assign range_err = err_q;
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;

      assign res_valid = op_valid;
      assign res_hi    = shifted[DW-1:WORD_W];
      assign res_lo    = shifted[WORD_W-1:0];
      assign pop_one   = dyn;
      assign cc        = cc_nxt;
      assign range_err = bad;
   end

endmodule

// File: rtl/shdw_stack_shifter_chk.sv
module shdw_stack_shifter_chk #(
   parameter int WORD_W     = 16,
   parameter int FLD_W      = 6,
   parameter bit REGISTERED = 1'b1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [FLD_W-1:0]  cnt_field,
   input logic              res_valid,
   input logic [WORD_W-1:0] res_hi,
   input logic [WORD_W-1:0] res_lo,
   input logic              pop_one,
   input logic [1:0]        cc,
   input logic              range_err
);

   logic neg_q;
   logic zero_q;
   assign neg_q  = res_hi[WORD_W-1];
   assign zero_q = (res_hi == '0) && (res_lo == '0);

   // R5: an out-of-window count leaves nothing but zeros and came from the stack
   p_range_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && range_err) |-> (zero_q && pop_one));

   // R1: static-count operations never flag a range error
   p_static_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !pop_one) |-> !range_err);

   // R6: condition code agrees with the result words
   p_cc_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && neg_q) |-> (cc == 2'b01));
   p_cc_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && zero_q) |-> (cc == 2'b10));
   p_cc_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !neg_q && !zero_q) |-> (cc == 2'b00));

   if (REGISTERED) begin : g_reg_props
      // R7: one clock from request to result
      p_lat_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
         op_valid |=> res_valid);
      p_lat_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !op_valid |=> !res_valid);
      // R2: a zero field pops the count word one clock later
      p_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (op_valid && cnt_field == '0) |=> pop_one);
      // R8: reset clears the valid and error outputs
      p_reset_r8: assert property (@(posedge clk)
         !rst_n |=> (!res_valid && !range_err));
   end else begin : g_comb_props
      // R7: same-cycle result
      p_same_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
         op_valid |-> res_valid);
   end

endmodule

bind shdw_stack_shifter shdw_stack_shifter_chk #(
   .WORD_W    (WORD_W),
   .FLD_W     (FLD_W),
   .REGISTERED(REGISTERED)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .cnt_field(cnt_field),
   .res_valid(res_valid),
   .res_hi   (res_hi),
   .res_lo   (res_lo),
   .pop_one  (pop_one),
   .cc       (cc),
   .range_err(range_err)
);

// File: tb/sim_shdw_stack_shifter.sv
module sim_shdw_stack_shifter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        dir_right = 1'b0;
   logic [5:0]  cnt_field = '0;
   logic [15:0] stk_a = '0, stk_b = '0, stk_c = '0;

   logic        r_vld, c_vld, r_pop, c_pop, r_err, c_err;
   logic [15:0] r_hi, r_lo, c_hi, c_lo;
   logic [1:0]  r_cc, c_cc;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] e_res;
   logic        e_pop, e_err;
   logic [1:0]  e_cc;

   always #4 clk = ~clk;

   shdw_stack_shifter #(.WORD_W(16), .FLD_W(6), .DYN_MAX(255), .REGISTERED(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .dir_right(dir_right),
      .cnt_field(cnt_field), .stk_a(stk_a), .stk_b(stk_b), .stk_c(stk_c),
      .res_valid(r_vld), .res_hi(r_hi), .res_lo(r_lo), .pop_one(r_pop),
      .cc(r_cc), .range_err(r_err));

   shdw_stack_shifter #(.WORD_W(16), .FLD_W(6), .DYN_MAX(255), .REGISTERED(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .dir_right(dir_right),
      .cnt_field(cnt_field), .stk_a(stk_a), .stk_b(stk_b), .stk_c(stk_c),
      .res_valid(c_vld), .res_hi(c_hi), .res_lo(c_lo), .pop_one(c_pop),
      .cc(c_cc), .range_err(c_err));

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // Behavioural reference built from the requirements.
   task automatic model(input logic dir, input logic [5:0] fld,
                        input logic [15:0] a, b, c);
      int cnt;
      logic [31:0] src;
      e_pop = (fld == 0);                              // R1 / R2
      src   = e_pop ? {c, b} : {b, a};
      cnt   = e_pop ? int'($signed(a)) : int'(fld);
      e_err = e_pop && (cnt < 0 || cnt > 255);         // R5
      if (e_err || cnt >= 32) e_res = 32'h0;           // R4 / R5
      else if (dir) e_res = src >> cnt;                // R3
      else e_res = src << cnt;
      if ($signed(e_res) < 0) e_cc = 2'b01;            // R6
      else if (e_res == 0) e_cc = 2'b10;
      else e_cc = 2'b00;
   endtask

   task automatic cmp(input string tag, input string who, input logic v,
                      input logic [15:0] hi, lo, input logic pop, err,
                      input logic [1:0] cc);
      checks++;
      if (v !== 1'b1 || {hi, lo} !== e_res || pop !== e_pop ||
          err !== e_err || cc !== e_cc) begin
         fails++;
         $display("FAIL %s %s: got v=%0d res=%h pop=%0d err=%0d cc=%b, expected v=1 res=%h pop=%0d err=%0d cc=%b",
                  tag, who, v, {hi, lo}, pop, err, cc, e_res, e_pop, e_err, e_cc);
      end
   endtask

   task automatic op(input string tag, input logic dir, input logic [5:0] fld,
                     input logic [15:0] a, b, c);
      @(negedge clk);
      op_valid = 1'b1; dir_right = dir; cnt_field = fld;
      stk_a = a; stk_b = b; stk_c = c;
      model(dir, fld, a, b, c);
      #1 cmp(tag, "comb", c_vld, c_hi, c_lo, c_pop, c_err, c_cc);
      @(posedge clk);
      #1 cmp(tag, "reg", r_vld, r_hi, r_lo, r_pop, r_err, r_cc);
   endtask

   task automatic idle_check();
      @(negedge clk);
      op_valid = 1'b0;
      #1 begin
         checks++;
         if (c_vld !== 1'b0) begin
            fails++;
            $display("FAIL R7 comb idle: got valid=%0d, expected 0", c_vld);
         end
      end
      @(posedge clk);
      #1 begin
         checks++;
         if (r_vld !== 1'b0) begin
            fails++;
            $display("FAIL R7 reg idle: got valid=%0d, expected 0", r_vld);
         end
      end
   endtask

   initial begin
      #(8 * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
   end

   initial begin
      // R8: drive an out-of-window request while in reset
      op_valid = 1'b1; cnt_field = 6'd0; stk_a = 16'hFFFF;
      repeat (3) @(posedge clk);
      #1 begin
         checks++;
         if (r_vld !== 1'b0 || r_err !== 1'b0) begin
            fails++;
            $display("FAIL R8 reset: got valid=%0d err=%0d, expected 0 0", r_vld, r_err);
         end
      end
      @(negedge clk);
      op_valid = 1'b0;
      rst_n = 1'b1;
      @(posedge clk);

      op("R1", 1'b0, 6'd1,  16'h8001, 16'h4000, 16'hDEAD);
      op("R1", 1'b1, 6'd5,  16'h00F0, 16'h1234, 16'hBEEF);
      op("R3", 1'b0, 6'd31, 16'h0001, 16'h0000, 16'h0000);
      op("R3", 1'b1, 6'd31, 16'h0000, 16'h8000, 16'h0000);
      op("R9", 1'b0, 6'd16, 16'hA5C3, 16'h0000, 16'h0000);
      op("R9", 1'b1, 6'd16, 16'h0000, 16'h5AA5, 16'h0000);
      op("R4", 1'b0, 6'd32, 16'hFFFF, 16'hFFFF, 16'hFFFF);
      op("R4", 1'b1, 6'd63, 16'hFFFF, 16'hFFFF, 16'hFFFF);
      op("R2", 1'b0, 6'd0,  16'd0,    16'h1357, 16'h9BDF);
      op("R2", 1'b0, 6'd0,  16'd17,   16'hFFFF, 16'h0001);
      op("R2", 1'b1, 6'd0,  16'd3,    16'h000F, 16'h8000);
      op("R4", 1'b0, 6'd0,  16'd32,   16'hFFFF, 16'hFFFF);
      op("R4", 1'b1, 6'd0,  16'd255,  16'hFFFF, 16'hFFFF);
      op("R5", 1'b0, 6'd0,  16'd256,  16'hFFFF, 16'hFFFF);
      op("R5", 1'b1, 6'd0,  16'hFFFF, 16'hFFFF, 16'hFFFF);
      op("R5", 1'b0, 6'd0,  16'h8000, 16'h0001, 16'h0001);
      op("R5", 1'b0, 6'd0,  16'h7FFF, 16'h0001, 16'h0001);
      op("R6", 1'b0, 6'd1,  16'h0000, 16'h4000, 16'h0000);
      op("R6", 1'b1, 6'd1,  16'h0001, 16'h0000, 16'h0000);
      op("R6", 1'b1, 6'd1,  16'h0000, 16'h8000, 16'h0000);
      idle_check();
      op("R7", 1'b0, 6'd4,  16'h1111, 16'h2222, 16'h3333);
      op("R7", 1'b1, 6'd9,  16'h4444, 16'h5555, 16'h6666);
      idle_check();

      for (int i = 0; i < 400; i++) begin
         logic [5:0]  f;
         logic [15:0] a;
         f = 6'($urandom_range(0, 63));
         if ($urandom_range(0, 2) == 0) f = 6'd0;
         a = 16'($urandom);
         if (f == 0 && $urandom_range(0, 1) == 0) a = 16'($urandom_range(0, 40));
         op("R3", 1'($urandom), f, a, 16'($urandom), 16'($urandom));
      end

      idle_check();
      finish_run();
   end

endmodule